// File: doc/BRIEF.md
# Segmented-Clock LCD Line Transmitter

This block converts a handshaked stream of 12-bit RGB pixels into the drive waveforms of a colour LCD. The panel's columns are handled by three driver chips. Each chip is clocked by a pair of strobe lines, and all three chips share one 4-bit data bus. Each accepted pixel word yields three 4-bit sub-pixel values. The block presents these values one at a time on the bus and pulses the strobe line that owns each sub-pixel, so one row costs 480 strobes.

A frame starts when a request arrives while the block is idle. Every line opens with a short gap. During the gap the block pulses a line-start output, raises a frame marker on the first line, and refuses input. The pixels for the line follow. The block also keeps a per-line down-counter with a polarity bit. In an alternate-timing mode the leading line of every strobe pair swaps on odd frames. The panel still receives each sub-pixel on the same line.

Top module: `lcd_tx_top`

## Requirements
- R1: A line takes PIXELS (160) accepted words. Each word gives three sub-pixels in this order: bits [11:8], then [7:4], then [3:0]. Sub-pixel s of the line is nibble (s mod 3) of pixel s/3.
- R2: Sub-pixel s is strobed on pair s/PIXELS, where pair index 0..2 selects output bit 0..2. Even s goes to `strobeA`, odd s to `strobeB`. At most one of the six strobe lines is high at any time, and each line pulses exactly PIXELS/2 (80) times per line.
- R3: Every strobe pulse is high for exactly two clock cycles.
- R4: In the cycle a strobe falls, `busData` holds the value of that strobe's sub-pixel. `busData` does not change in that cycle, and it only changes while every strobe is low.
- R5: A word transfers when `pixValid` and `pixReady` are both high at a clock edge. `pixReady` is low throughout the LINE_GAP-cycle gap at the start of each line and while the block is idle.
- R6: `lineStart` is high for one cycle at the start of every line. `frameMark` is high only together with the `lineStart` of line 0. A frame is LINES lines long and starts only on `frameReq` while idle; a `frameReq` during a frame has no effect.
- R7: After reset, `rowCount` is 0xF and `rowPhase` is 0. `rowCount` drops by one when each line completes. On the step from 0x0 to 0xF, `rowPhase` toggles.
- R8: Frames are numbered from 0 after reset, and `altMode` is sampled with `frameReq`. If it is set on an odd frame, the odd member of every sub-pixel pair (2k, 2k+1) is strobed first. In every other case the sub-pixels go out in ascending order. The mapping of R2 holds in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameReq | input | 1 | Start a frame when idle |
| altMode | input | 1 | Alternate pair-lead timing, sampled at frame start |
| pixValid | input | 1 | Pixel word available |
| pixData | input | 12 | RGB 4:4:4 pixel word |
| pixReady | output | 1 | Block accepts a pixel word |
| strobeA | output | 3 | Even sub-pixel strobes, one per pair |
| strobeB | output | 3 | Odd sub-pixel strobes, one per pair |
| busData | output | 4 | Shared sub-pixel data bus |
| lineStart | output | 1 | One-cycle pulse at each line start |
| frameMark | output | 1 | Marks the start of line 0 |
| rowCount | output | 4 | Per-line down-counter |
| rowPhase | output | 1 | Toggles on each counter wrap |

## Verification
A wrong slot or pair index appears within one strobe pulse: the wrong line falls, or it falls with the wrong nibble. The scoreboard, which compares every falling edge in order, flags the next sub-pixel. A corrupted swap flag is caught at the first sub-pixel of an odd frame. A miscounted group or line counter appears at the next line start as a wrong per-line pulse total, a misplaced frame marker or a wrong counter value. A wrong counter or polarity bit is visible at the line start that follows the fault.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int SUBS_PER_PIX = 3;
  localparam int GROUP_SUBS = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_LOAD, ST_EMIT} txState_t;

  typedef struct packed {
    logic       loadLo;
    logic       loadHi;
    logic       setData;
    logic       strobeOn;
    logic [2:0] slot;
    logic [1:0] pairSel;
    logic       oddSide;
  } txCtl_t;
endpackage

// File: rtl/lcd_tx_ctrl.sv
module lcd_tx_ctrl
  import lcd_tx_pkg::*;
#(
  parameter int PIXELS   = 160,
  parameter int LINES    = 144,
  parameter int LINE_GAP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameReq,
  input  logic       altMode,
  input  logic       pixValid,
  output logic       pixReady,
  output logic       lineStart,
  output logic       frameMark,
  output logic [3:0] rowCount,
  output logic       rowPhase,
  output txCtl_t     ctl
);
  localparam int GROUPS = PIXELS / 2;
  localparam int SUBPIX = PIXELS * SUBS_PER_PIX;
  localparam int GAP_W  = $clog2(LINE_GAP + 1);
  localparam int LINE_W = $clog2(LINES + 1);
  localparam int GRP_W  = $clog2(GROUPS + 1);
  localparam int SP_W   = $clog2(SUBPIX + 1);

  txState_t           state;
  logic [GAP_W-1:0]   gapCnt;
  logic [LINE_W-1:0]  lineCnt;
  logic [GRP_W-1:0]   grpCnt;
  logic               pixSel;
  logic [2:0]         slot;
  logic [1:0]         phase;
  logic               swapFlag;
  logic               frameOdd;
  logic [2:0]         slotPhys;
  logic [SP_W-1:0]    spIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapCnt   <= '0;
      lineCnt  <= '0;
      grpCnt   <= '0;
      pixSel   <= 1'b0;
      slot     <= '0;
      phase    <= '0;
      swapFlag <= 1'b0;
      frameOdd <= 1'b0;
      rowCount <= 4'hF;
      rowPhase <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (frameReq) begin
          swapFlag <= altMode & frameOdd;
          frameOdd <= ~frameOdd;
          lineCnt  <= '0;
          gapCnt   <= '0;
          state    <= ST_GAP;
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(LINE_GAP - 1)) begin
            grpCnt <= '0;
            pixSel <= 1'b0;
            state  <= ST_LOAD;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_LOAD: if (pixValid) begin
          if (pixSel) begin
            slot  <= '0;
            phase <= '0;
            state <= ST_EMIT;
          end else begin
            pixSel <= 1'b1;
          end
        end
        ST_EMIT: begin
          phase <= phase + 1'b1;
          if (phase == 2'd3) begin
            if (slot == 3'(GROUP_SUBS - 1)) begin
              if (grpCnt == GRP_W'(GROUPS - 1)) begin
                rowCount <= rowCount - 4'd1;
                if (rowCount == 4'h0) rowPhase <= ~rowPhase;
                if (lineCnt == LINE_W'(LINES - 1)) begin
                  state <= ST_IDLE;
                end else begin
                  lineCnt <= lineCnt + 1'b1;
                  gapCnt  <= '0;
                  state   <= ST_GAP;
                end
              end else begin
                grpCnt <= grpCnt + 1'b1;
                pixSel <= 1'b0;
                state  <= ST_LOAD;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    slotPhys = swapFlag ? (slot ^ 3'd1) : slot;
    spIdx    = SP_W'(grpCnt) * SP_W'(GROUP_SUBS) + SP_W'(slotPhys);
    ctl.loadLo   = (state == ST_LOAD) && pixValid && !pixSel;
    ctl.loadHi   = (state == ST_LOAD) && pixValid && pixSel;
    ctl.setData  = (state == ST_EMIT) && (phase == 2'd0);
    ctl.strobeOn = (state == ST_EMIT) && ((phase == 2'd1) || (phase == 2'd2));
    ctl.slot     = slotPhys;
    ctl.oddSide  = slotPhys[0];
    if (spIdx >= SP_W'(2 * PIXELS))  ctl.pairSel = 2'd2;
    else if (spIdx >= SP_W'(PIXELS)) ctl.pairSel = 2'd1;
    else                             ctl.pairSel = 2'd0;
  end

  assign pixReady  = (state == ST_LOAD);
  assign lineStart = (state == ST_GAP) && (gapCnt == '0);
  assign frameMark = lineStart && (lineCnt == '0);
endmodule

// File: rtl/lcd_tx_datapath.sv
module lcd_tx_datapath
  import lcd_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  txCtl_t               ctl,
  input  logic [11:0]          pixData,
  output logic [NUM_PAIRS-1:0] strobeA,
  output logic [NUM_PAIRS-1:0] strobeB,
  output logic [3:0]           busData
);
  logic [23:0] grpWord;
  logic [11:0] word;
  logic [1:0]  comp;
  logic [3:0]  nibble;

  always_comb begin
    word = (ctl.slot < 3'd3) ? grpWord[11:0] : grpWord[23:12];
    comp = (ctl.slot < 3'd3) ? ctl.slot[1:0] : 2'(ctl.slot - 3'd3);
    case (comp)
      2'd0:    nibble = word[11:8];
      2'd1:    nibble = word[7:4];
      default: nibble = word[3:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpWord <= '0;
      busData <= '0;
    end else begin
      if (ctl.loadLo)  grpWord[11:0]  <= pixData;
      if (ctl.loadHi)  grpWord[23:12] <= pixData;
      if (ctl.setData) busData        <= nibble;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rstN) begin
        strobeA[p] <= 1'b0;
        strobeB[p] <= 1'b0;
      end else begin
        strobeA[p] <= ctl.strobeOn && (ctl.pairSel == 2'(p)) && !ctl.oddSide;
        strobeB[p] <= ctl.strobeOn && (ctl.pairSel == 2'(p)) && ctl.oddSide;
      end
    end
  end
endmodule

// File: rtl/lcd_tx_top.sv
module lcd_tx_top
  import lcd_tx_pkg::*;
#(
  parameter int PIXELS   = 160,
  parameter int LINES    = 144,
  parameter int LINE_GAP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameReq,
  input  logic        altMode,
  input  logic        pixValid,
  input  logic [11:0] pixData,
  output logic        pixReady,
  output logic [2:0]  strobeA,
  output logic [2:0]  strobeB,
  output logic [3:0]  busData,
  output logic        lineStart,
  output logic        frameMark,
  output logic [3:0]  rowCount,
  output logic        rowPhase
);
  txCtl_t ctl;

  lcd_tx_ctrl #(.PIXELS(PIXELS), .LINES(LINES), .LINE_GAP(LINE_GAP)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameReq(frameReq), .altMode(altMode),
    .pixValid(pixValid), .pixReady(pixReady), .lineStart(lineStart),
    .frameMark(frameMark), .rowCount(rowCount), .rowPhase(rowPhase), .ctl(ctl)
  );

  lcd_tx_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixData(pixData),
    .strobeA(strobeA), .strobeB(strobeB), .busData(busData)
  );
endmodule

// File: rtl/lcd_tx_chk.sv
module lcd_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] strobeA,
  input logic [2:0] strobeB,
  input logic [3:0] busData,
  input logic       lineStart,
  input logic       frameMark,
  input logic       pixReady,
  input logic [3:0] rowCount,
  input logic       rowPhase
);
  logic anyStrobe;
  assign anyStrobe = |{strobeA, strobeB};

  // R2: one strobe line at a time
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobeA, strobeB}) <= 1);

  // R3: pulse stays high for a second cycle
  a_r3_pulse_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyStrobe) |=> anyStrobe);

  // R3: no pulse longer than two cycles
  a_r3_pulse_max: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && $past(anyStrobe)) |=> !anyStrobe);

  // R4: bus holds across the falling edge
  a_r4_hold_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> $stable(busData));

  // R4: bus changes only with all strobes low
  a_r4_change_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(busData) |-> (!anyStrobe && !$past(anyStrobe)));

  // R5: no input acceptance in the line gap
  a_r5_ready_gap: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> !pixReady);

  // R6: frame marker only with a line start
  a_r6_frame_mark: assert property (@(posedge clk) disable iff (!rstN)
    frameMark |-> lineStart);

  // R7: counter only steps down by one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowCount) |-> (rowCount == $past(rowCount) - 4'd1));

  // R7: polarity toggles only on wrap
  a_r7_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowPhase) |-> ($past(rowCount) == 4'h0 && rowCount == 4'hF));
endmodule

bind lcd_tx_top lcd_tx_chk i_chk (
  .clk(clk), .rstN(rstN), .strobeA(strobeA), .strobeB(strobeB),
  .busData(busData), .lineStart(lineStart), .frameMark(frameMark),
  .pixReady(pixReady), .rowCount(rowCount), .rowPhase(rowPhase)
);

// File: tb/test_lcd_tx_top.sv
module test_lcd_tx_top;
  localparam int PIX = 160;
  localparam int LNS = 6;
  localparam int GAP = 4;
  localparam int FRAMES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameReq = 1'b0, altMode = 1'b0, pixValid = 1'b0;
  logic [11:0] pixData = '0;
  logic pixReady, lineStart, frameMark, rowPhase;
  logic [2:0] strobeA, strobeB;
  logic [3:0] busData, rowCount;

  int tests = 0, fails = 0;
  logic [6:0] expQ[$];
  int pulses[6];
  int globalLine = 0;
  logic [5:0] prevStb = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  lcd_tx_top #(.PIXELS(PIX), .LINES(LNS), .LINE_GAP(GAP)) i_lcd_tx_top (
    .clk(clk), .rstN(rstN), .frameReq(frameReq), .altMode(altMode),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .strobeA(strobeA), .strobeB(strobeB), .busData(busData),
    .lineStart(lineStart), .frameMark(frameMark),
    .rowCount(rowCount), .rowPhase(rowPhase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pixVal(int f, int ln, int p);
    return 12'((f * 1237 + ln * 97 + p * 29 + 5) & 12'hFFF);
  endfunction

  // Monitor: each strobe fall pops one expected {lineId, nibble}
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        logic [5:0] cur;
        cur = {strobeB, strobeA};
        for (int i = 0; i < 6; i++) begin
          if (prevStb[i] && !cur[i]) begin
            pulses[i]++;
            if (expQ.size() == 0) begin
              chk(0, "R2 unexpected strobe", i, -1);
            end else begin
              logic [6:0] e;
              e = expQ.pop_front();
              // R2/R8: line carrying this sub-pixel; R1/R4: its nibble
              chk(int'(e[6:4]) == i, "R2/R8 strobe line", i, int'(e[6:4]));
              chk(busData == e[3:0], "R1/R4 data at fall", int'(busData), int'(e[3:0]));
            end
          end
        end
        prevStb = cur;
        if (lineStart) begin
          if (globalLine > 0)
            for (int i = 0; i < 6; i++) chk(pulses[i] == PIX / 2, "R2 pulses per line", pulses[i], PIX / 2);
          for (int i = 0; i < 6; i++) pulses[i] = 0;
          chk(frameMark == ((globalLine % LNS) == 0), "R6 frame marker", int'(frameMark), int'((globalLine % LNS) == 0));
          chk(!pixReady, "R5 ready low in gap", int'(pixReady), 0);
          chk(rowCount == 4'(15 - (globalLine % 16)), "R7 row counter", int'(rowCount), 15 - (globalLine % 16));
          chk(rowPhase == 1'((globalLine / 16) % 2), "R7 row phase", int'(rowPhase), (globalLine / 16) % 2);
          globalLine++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) pulses[i] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state: R7, R5, R2
    chk(rowCount == 4'hF, "R7 reset count", int'(rowCount), 15);
    chk(rowPhase == 1'b0, "R7 reset phase", int'(rowPhase), 0);
    chk(!pixReady, "R5 idle not ready", int'(pixReady), 0);
    chk({strobeA, strobeB} == '0, "R2 reset strobes", int'({strobeA, strobeB}), 0);
    chk(!lineStart, "R6 idle no line", int'(lineStart), 0);

    for (int f = 0; f < FRAMES; f++) begin
      bit alt, swp;
      logic [11:0] lastPix;
      alt = (f < 2);
      swp = alt && (f % 2 == 1);   // R8: only odd frame with mode set swaps
      @(negedge clk);
      frameReq = 1'b1;
      altMode  = alt;
      @(negedge clk);
      frameReq = 1'b0;
      altMode  = 1'b0;
      lastPix  = '0;
      for (int ln = 0; ln < LNS; ln++) begin
        for (int p = 0; p < PIX; p++) begin
          bit done;
          done = 0;
          while (!done) begin
            @(negedge clk);
            // R6: a request in mid-frame must be ignored
            frameReq = (f == 0 && ln == 2 && p == 10);
            pixValid = (($urandom % 4) != 0);
            pixData  = pixVal(f, ln, p);
            if (pixValid && pixReady) done = 1;
          end
          if (p % 2 == 0) begin
            lastPix = pixData;
          end else begin
            for (int k = 0; k < 6; k++) begin
              int o, sp;
              logic [11:0] w;
              logic [3:0] nib;
              o  = swp ? (k ^ 1) : k;
              sp = (p / 2) * 6 + o;
              w  = (o < 3) ? lastPix : pixData;
              case (o % 3)
                0: nib = w[11:8];
                1: nib = w[7:4];
                default: nib = w[3:0];
              endcase
              expQ.push_back({3'((sp % 2) * 3 + sp / PIX), nib});
            end
          end
        end
        @(negedge clk);
        pixValid = 1'b0;
        frameReq = 1'b0;
      end
      while (expQ.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      // R6: frame has ended, block idle and not accepting
      chk(!pixReady, "R6 idle after frame", int'(pixReady), 0);
      chk(globalLine == (f + 1) * LNS, "R6 lines per frame", globalLine, (f + 1) * LNS);
    end
    for (int i = 0; i < 6; i++) chk(pulses[i] == PIX / 2, "R2 pulses last line", pulses[i], PIX / 2);
    chk(expQ.size() == 0, "R1 all sub-pixels sent", expQ.size(), 0);
    chk(rowCount == 4'(15 - (globalLine % 16)), "R7 final count", int'(rowCount), 15 - (globalLine % 16));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule